// File: doc/BRIEF.md
# Self-Test Global Enable Controller

This block sits between software and a memory self-test engine and decides when that engine may run. Software arms the self-test by writing a 4-bit key into a global control register. Only one key value turns the test on and only one other value turns it off. The same register carries a 2-bit field that selects how much slower the test-ROM clock runs than the bus clock.

Once the test is armed, the block waits for a settling time. The length of this wait depends on the clock ratio in force. After it, the block raises `ready` and emits a clock-enable, `rom_clk_en`, that marks the test-ROM clock edges at the selected rate.

A separate register holds the enable bit for the test controller. A status register holds a sticky completion flag. The engine sets this flag, software polls it, and software clears it.

Top module: `stg_ctrl`

Register addresses on `wr_addr` and `rd_addr`:
- 0: global control.
- 1: controller enable.
- 2: status.

Reads are combinational.

## Requirements
- R1: After reset:
  - the test is disabled and the global control register reads 0x0005 (key field 0x5, divider field 0);
  - `ready`, `rom_clk_en` and `ctrl_en` are 0;
  - the status register reads 0.
- R2: A write to address 0 with bits 3:0 equal to 0xA enables the test. `test_on` is 1 and `ready` is 0 in the cycle after the write.
- R3: A write to address 0 with bits 3:0 equal to 0x5 disables the test. `test_on`, `ready` and `rom_clk_en` are 0 in the cycle after the write.
- R4: A write to address 0 whose key is neither 0xA nor 0x5 leaves the enable state unchanged. Bits 3:0 of address 0 read 0xA while enabled and 0x5 while disabled.
- R5: `ready` rises exactly N cycles after the enabling write edge. The divider code selects N: code 0 gives 16, code 1 gives 32, and codes 2 and 3 give 64. `ready` is only ever high while the test is enabled.
- R6: While `ready` is high, `rom_clk_en` is high in the first ready cycle and then once every P cycles. The divider code selects P: codes 0, 1, 2 and 3 give 1, 2, 4 and 8. `rom_clk_en` is never high while `ready` is low.
- R7: The divider field (bits 9:8 of address 0) reads back the last value written. A change while enabled does not alter the active ratio until the next 0xA write.
- R8: Bit 1 of address 1 drives `ctrl_en` and reads back at bit 1. The other bits of that register are ignored.
- R9: A high `engine_done` sets the sticky done flag, read at bit 0 of address 2, in the next cycle.
- R10: The done flag is cleared by writing 1 to bit 0 of address 2, or by a 0xA enable write. An `engine_done` in the same cycle takes priority over either clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Read data, combinational |
| engine_done | input | 1 | Completion pulse from the self-test engine |
| test_on | output | 1 | Self-test enabled |
| ctrl_en | output | 1 | Test controller enable |
| ready | output | 1 | Settling complete, ROM clock usable |
| rom_clk_en | output | 1 | ROM clock-domain enable pulse |

## Verification
The assertions hold the following every cycle:
- `ready` implies enabled, and `rom_clk_en` implies `ready`.
- An off-key write drops both outputs and an on-key write restarts settling.
- Unknown keys leave the enable state alone.
- The done flag obeys its set and clear priority.

Only the bench scenarios can show two things. The first is the exact settling length for each divider code and the pulse spacing of `rom_clk_en`. The second is that a divider change while running is deferred, because both depend on counting whole windows after a specific write.

// File: rtl/stg_pkg.sv
package stg_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int KEY_W  = 4;
    localparam int CNT_W  = 7;
    localparam int PH_W   = 3;

    localparam logic [KEY_W-1:0] KEY_ON  = 4'hA;
    localparam logic [KEY_W-1:0] KEY_OFF = 4'h5;

    localparam logic [ADDR_W-1:0] A_GCTL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CEN  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

    localparam int DIV_LO = 8;
    localparam int CEN_BIT = 1;

    typedef enum logic [1:0] {
        RATIO_1 = 2'd0,
        RATIO_2 = 2'd1,
        RATIO_4 = 2'd2,
        RATIO_8 = 2'd3
    } ratio_e;

    typedef struct packed {
        logic   on;
        ratio_e active;
        ratio_e field;
        logic   cen;
        logic   done;
    } ctl_state_t;

    function automatic logic [CNT_W-1:0] settle_len(ratio_e r);
        case (r)
            RATIO_1: settle_len = CNT_W'(16);
            RATIO_2: settle_len = CNT_W'(32);
            default: settle_len = CNT_W'(64);
        endcase
    endfunction

    function automatic logic [PH_W-1:0] phase_mask(ratio_e r);
        phase_mask = PH_W'((1 << r) - 1);
    endfunction

endpackage

// File: rtl/stg_regs.sv
module stg_regs
    import stg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                engine_done,
    output logic                start,
    output ctl_state_t          st
);
    logic              gctl_wr;
    logic              stat_wr;
    logic [KEY_W-1:0]  key;
    logic              stop;
    logic              clr_done;

    assign gctl_wr  = wr_en && (wr_addr == A_GCTL);
    assign stat_wr  = wr_en && (wr_addr == A_STAT);
    assign key      = wr_data[KEY_W-1:0];
    assign start    = gctl_wr && (key == KEY_ON);
    assign stop     = gctl_wr && (key == KEY_OFF);
    assign clr_done = start || (stat_wr && wr_data[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{on: 1'b0, active: RATIO_1, field: RATIO_1, cen: 1'b0, done: 1'b0};
        end else begin
            if (gctl_wr)
                st.field <= ratio_e'(wr_data[DIV_LO+1:DIV_LO]);
            if (start) begin
                st.on     <= 1'b1;
                st.active <= ratio_e'(wr_data[DIV_LO+1:DIV_LO]);
            end else if (stop) begin
                st.on <= 1'b0;
            end
            if (wr_en && (wr_addr == A_CEN))
                st.cen <= wr_data[CEN_BIT];
            if (engine_done)
                st.done <= 1'b1;
            else if (clr_done)
                st.done <= 1'b0;
        end
    end
endmodule

// File: rtl/stg_settle.sv
module stg_settle
    import stg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   on,
    input  ratio_e ratio_next,
    output logic   ready
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= settle_len(ratio_next);
        else if (!on)
            remain <= '0;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign ready = on && (remain == '0);
endmodule

// File: rtl/stg_clkdiv.sv
module stg_clkdiv
    import stg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ready,
    input  ratio_e ratio,
    output logic   rom_clk_en
);
    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !ready)
            phase <= '0;
        else
            phase <= (phase + 1'b1) & phase_mask(ratio);
    end

    assign rom_clk_en = ready && (phase == '0);
endmodule

// File: rtl/stg_ctrl.sv
module stg_ctrl
    import stg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [15:0]       rd_data,
    input  logic              engine_done,
    output logic              test_on,
    output logic              ctrl_en,
    output logic              ready,
    output logic              rom_clk_en
);
    ctl_state_t st;
    logic       start;
    logic       done_q;
    ratio_e     act_ratio;

    stg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .engine_done(engine_done),
        .start(start), .st(st)
    );

    stg_settle u_settle (
        .clk(clk), .rst(rst), .start(start), .on(st.on),
        .ratio_next(ratio_e'(wr_data[DIV_LO+1:DIV_LO])), .ready(ready)
    );

    stg_clkdiv u_div (
        .clk(clk), .rst(rst), .ready(ready), .ratio(st.active),
        .rom_clk_en(rom_clk_en)
    );

    assign test_on   = st.on;
    assign ctrl_en   = st.cen;
    assign done_q    = st.done;
    assign act_ratio = st.active;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_GCTL: begin
                rd_data[DIV_LO+1:DIV_LO] = st.field;
                rd_data[KEY_W-1:0]       = st.on ? KEY_ON : KEY_OFF;
            end
            A_CEN:  rd_data[CEN_BIT] = st.cen;
            A_STAT: rd_data[0]       = st.done;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/stg_ctrl_chk.sv
module stg_ctrl_chk
    import stg_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic        engine_done,
    input logic        test_on,
    input logic        ready,
    input logic        rom_clk_en,
    input logic        done_q,
    input ratio_e      act_ratio
);
    logic key_on_wr, key_off_wr, key_other_wr, stat_clr_wr;
    assign key_on_wr    = wr_en && wr_addr == A_GCTL && wr_data[3:0] == KEY_ON;
    assign key_off_wr   = wr_en && wr_addr == A_GCTL && wr_data[3:0] == KEY_OFF;
    assign key_other_wr = wr_en && wr_addr == A_GCTL && !key_on_wr && !key_off_wr;
    assign stat_clr_wr  = wr_en && wr_addr == A_STAT && wr_data[0];

    a_r2_on_restarts: assert property (@(posedge clk) disable iff (rst)
        key_on_wr |=> test_on && !ready);
    a_r3_off_drops: assert property (@(posedge clk) disable iff (rst)
        key_off_wr |=> !test_on && !ready && !rom_clk_en);
    a_r4_other_key_keeps: assert property (@(posedge clk) disable iff (rst)
        key_other_wr |=> test_on == $past(test_on));
    a_r5_ready_needs_on: assert property (@(posedge clk) disable iff (rst)
        ready |-> test_on);
    a_r6_pulse_needs_ready: assert property (@(posedge clk) disable iff (rst)
        rom_clk_en |-> ready);
    a_r6_full_rate: assert property (@(posedge clk) disable iff (rst)
        (ready && act_ratio == RATIO_1) |-> rom_clk_en);
    a_r9_done_sets: assert property (@(posedge clk) disable iff (rst)
        engine_done |=> done_q);
    a_r10_done_clears: assert property (@(posedge clk) disable iff (rst)
        ((key_on_wr || stat_clr_wr) && !engine_done) |=> !done_q);
endmodule

bind stg_ctrl stg_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .engine_done(engine_done), .test_on(test_on), .ready(ready),
    .rom_clk_en(rom_clk_en), .done_q(done_q), .act_ratio(act_ratio)
);

// File: tb/sim_stg_ctrl.sv
`timescale 1ns/1ps
module sim_stg_ctrl;
    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [1:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic [1:0]  rd_addr = 0;
    logic [15:0] rd_data;
    logic        engine_done = 0;
    logic        test_on, ctrl_en, ready, rom_clk_en;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    localparam int S_RD = 0, S_RDY = 1, S_ROM = 2, S_CEN = 3, S_ON = 4;

    always #2 clk = ~clk;

    stg_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .engine_done(engine_done),
        .test_on(test_on), .ctrl_en(ctrl_en), .ready(ready), .rom_clk_en(rom_clk_en)
    );

    function automatic logic [15:0] actual(int sel);
        case (sel)
            S_RD:    return rd_data;
            S_RDY:   return {15'b0, ready};
            S_ROM:   return {15'b0, rom_clk_en};
            S_CEN:   return {15'b0, ctrl_en};
            default: return {15'b0, test_on};
        endcase
    endfunction

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                act = actual(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(int sel, logic [15:0] exp, string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic read_expect(logic [1:0] a, logic [15:0] exp, string tag);
        rd_addr = a;
        expect_item(S_RD, exp, tag);
    endtask

    task automatic do_write(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0; wr_data = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // enable at a ratio, check settle length and pulse spacing
    task automatic settle_run(int code);
        int n;
        int p;
        n = (code == 0) ? 16 : (code == 1) ? 32 : 64;
        p = 1 << code;
        do_write(2'd0, 16'(code << 8) | 16'h000A);
        expect_item(S_RDY, 0, "R2 ready low after enable");
        repeat (n - 1) @(posedge clk);
        #1;
        expect_item(S_RDY, 0, "R5 ready low one cycle before settle end");
        step();
        expect_item(S_RDY, 1, "R5 ready high at settle end");
        for (int i = 0; i < 8; i++) begin
            expect_item(S_ROM, ((i % p) == 0) ? 16'd1 : 16'd0, "R6 rom_clk_en spacing");
            step();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        step();
        // R1
        read_expect(2'd0, 16'h0005, "R1 control reset value");
        expect_item(S_RDY, 0, "R1 ready reset");
        expect_item(S_ROM, 0, "R1 rom_clk_en reset");
        expect_item(S_CEN, 0, "R1 ctrl_en reset");
        step();
        read_expect(2'd2, 16'h0000, "R1 status reset");
        step();

        // R5 / R6 across all ratios
        for (int c = 0; c < 4; c++) begin
            settle_run(c);
            read_expect(2'd0, 16'(c << 8) | 16'h000A, "R4 key reads 0xA while enabled");
            step();
        end

        // R7: change divider while enabled at ratio 1:2
        settle_run(1);
        do_write(2'd0, 16'h0300);          // key 0: R4 no change
        expect_item(S_ON, 1, "R4 other key keeps enabled");
        read_expect(2'd0, 16'h030A, "R7 divider field readback");
        step();
        // ready still high; phase continues at period 2
        begin
            int ones;
            ones = 0;
            for (int i = 0; i < 8; i++) begin
                if (rom_clk_en) ones++;
                step();
            end
            checks++;
            if (ones != 4) begin
                errors++;
                $display("FAIL R7 active ratio kept: actual=%0d pulses expected=4", ones);
            end
        end

        // R3 disable
        do_write(2'd0, 16'h0005);
        expect_item(S_RDY, 0, "R3 ready drops");
        expect_item(S_ROM, 0, "R3 rom_clk_en drops");
        expect_item(S_ON, 0, "R3 disabled");
        step();
        read_expect(2'd0, 16'h0005, "R4 key reads 0x5 when disabled");
        step();
        do_write(2'd0, 16'h000F);
        expect_item(S_ON, 0, "R4 other key keeps disabled");
        step();

        // R8
        do_write(2'd1, 16'h0002);
        expect_item(S_CEN, 1, "R8 ctrl_en set");
        read_expect(2'd1, 16'h0002, "R8 ctrl readback");
        step();
        do_write(2'd1, 16'hFFFD);
        expect_item(S_CEN, 0, "R8 other bits ignored");
        step();

        // R9 / R10
        @(negedge clk) engine_done = 1;
        @(posedge clk); #1 engine_done = 0;
        read_expect(2'd2, 16'h0001, "R9 done set");
        step();
        do_write(2'd2, 16'h0000);
        read_expect(2'd2, 16'h0001, "R10 write 0 keeps done");
        step();
        do_write(2'd2, 16'h0001);
        read_expect(2'd2, 16'h0000, "R10 write 1 clears done");
        step();
        @(negedge clk) begin
            engine_done = 1; wr_en = 1; wr_addr = 2'd2; wr_data = 16'h0001;
        end
        @(posedge clk); #1 begin engine_done = 0; wr_en = 0; wr_data = 0; end
        read_expect(2'd2, 16'h0001, "R10 set wins over clear");
        step();
        do_write(2'd0, 16'h000A);
        read_expect(2'd2, 16'h0000, "R10 enable clears done");
        step();

        step(); step();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule